// File: doc/BRIEF.md
# Branch Target Buffer with Return Stack

This block predicts control flow for the fetch stage of a 32-bit in-order pipeline. Every cycle, fetch presents its PC on the lookup side. The block answers combinationally with four results: whether a stored entry matches, whether that entry predicts taken, the slot index of the match, and the predicted target. The buffer is fully associative with 32 slots. Each slot holds a PC tag, a target, a 2-bit direction counter and a flag that marks the slot as a function return.

Training comes from decode. Once an instruction is resolved, decode reports what happened as a set of commands: allocate, invalidate, direction correction, target correction and confirmation. The report also carries the resolved direction and target, and it echoes back the slot index that lookup gave. A link-and-branch instruction pushes its return address (PC + 4) onto an 8-deep return stack, and a register-indirect jump pops it. A hit on a slot marked as a return takes its target from the top of that stack.

Top module: `btb_ras`

## Requirements
- R1: While reset is held, and after it is released, every slot is invalid and the return stack is empty. Lookup reports hit=0, taken=0, index=0 and target=0 for any PC, and it does so on every miss.
- R2: An update is accepted only when up_inst_valid, up_ready_go and up_next_ready are all 1 and up_fetch_excp is 0. Without acceptance, no command and no stack operation has any effect.
- R3: An accepted add writes the update PC and target into the lowest-numbered invalid slot. The counter is set to weakly taken (2), so a later lookup of that PC hits with taken=1 and reports that slot's index.
- R4: When all slots are valid, an add goes to the slot named by a victim pointer. The pointer starts at 0 after reset and advances by one, wrapping after 31, on each add into a full buffer.
- R5: An accepted delete invalidates slot up_idx.
- R6: An accepted direction error or confirm moves the counter of slot up_idx one step toward up_taken, saturating at 0 and 3. Counter values are 0 strongly not-taken, 1 weakly not-taken, 2 weakly taken and 3 strongly taken. Lookup reports taken when bit 1 of the counter is 1.
- R7: An accepted target error replaces the stored target of slot up_idx with up_target.
- R8: An accepted push stores up_pc+4 on the return stack. A slot allocated while up_pop=1 is marked as a return. A hit on a return slot with a non-empty stack reports the stack top as target.
- R9: An accepted pop removes the top entry. A pop on an empty stack changes nothing, and a return slot hit with an empty stack reports its stored target.
- R10: The stack holds 8 entries. A push into a full stack overwrites the oldest entry, so 9 pushes followed by pops return the last 8 values, newest first, and then the stack is empty.
- R11: A lookup in the same cycle as an update that changes the looked-up state returns the contents from before that update.
- R12: Command priority per update is: add first, then delete, then the counter and target commands. Push wins over pop when both are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_hit | output | 1 | A valid slot matches lk_pc |
| lk_taken | output | 1 | The matching slot predicts taken |
| lk_idx | output | 5 | Index of the matching slot |
| lk_target | output | 32 | Predicted target |
| up_inst_valid | input | 1 | Decode holds a valid instruction |
| up_ready_go | input | 1 | Decode instruction can advance |
| up_next_ready | input | 1 | Next stage accepts it |
| up_fetch_excp | input | 1 | Fetch flagged an exception for it |
| up_add | input | 1 | Allocate a slot for up_pc |
| up_delete | input | 1 | Invalidate slot up_idx |
| up_dir_err | input | 1 | Direction mispredicted on slot up_idx |
| up_tgt_err | input | 1 | Target mispredicted on slot up_idx |
| up_confirm | input | 1 | Direction predicted correctly on slot up_idx |
| up_push | input | 1 | Link call: push up_pc+4 |
| up_pop | input | 1 | Indirect return: pop stack, mark allocated slot as return |
| up_taken | input | 1 | Resolved direction |
| up_idx | input | 5 | Slot index echoed from lookup |
| up_pc | input | 32 | PC of the resolved instruction |
| up_target | input | 32 | Resolved target |

## Verification
Lookup and update operate every cycle, so the most important collision is a fetch lookup of the very PC or slot that decode is rewriting in that cycle. The same applies to a return-slot lookup while the stack is being pushed or popped. The bench drives lk_pc to the same PC as up_pc in directed steps and in a large share of random cycles. It samples the lookup result before the clock edge and judges it against a reference model that has not yet applied the update. A second collision is several commands in one update; this is provoked by asserting add together with delete, and push together with pop, and is judged against the stated priority.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef logic [1:0] dir_ctr_t;
  localparam dir_ctr_t CTR_WEAK_TAKEN = 2'b10;

  // one saturating step toward the resolved direction
  function automatic dir_ctr_t ctr_step(input dir_ctr_t c, input logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'b01;
    else       return (c == 2'b00) ? c : c - 2'b01;
  endfunction
endpackage

// File: rtl/btb_alloc.sv
module btb_alloc #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  valid_vec,
  input  logic          alloc_fire,
  output logic [IW-1:0] alloc_idx
);
  logic [IW-1:0] vptr_q, vptr_d, free_idx;
  logic          has_free;

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        has_free = 1'b1;
        free_idx = IW'(i);
      end
    end
    alloc_idx = has_free ? free_idx : vptr_q;
    vptr_d    = (vptr_q == IW'(N - 1)) ? '0 : vptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vptr_q <= '0;
    else if (alloc_fire && !has_free) vptr_q <= vptr_d;
  end

  // R4
  victim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && !has_free) |=> (vptr_q != $past(vptr_q)));
endmodule

// File: rtl/btb_store.sv
module btb_store import btb_pkg::*; #(
  parameter int N  = 32,
  parameter int IW = 5,
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] lk_pc,
  output logic          lk_hit,
  output logic          lk_taken,
  output logic          lk_ret,
  output logic [IW-1:0] lk_idx,
  output logic [XW-1:0] lk_tgt,
  output logic [N-1:0]  valid_vec,
  input  logic          wr_add,
  input  logic [IW-1:0] add_idx,
  input  logic          add_ret,
  input  logic          wr_del,
  input  logic          wr_dir,
  input  logic          wr_tgt,
  input  logic [IW-1:0] up_idx,
  input  logic          up_taken,
  input  logic [XW-1:0] up_pc,
  input  logic [XW-1:0] up_target
);
  logic [N-1:0]  valid_q, valid_d;
  logic [XW-1:0] tag_q [N];
  logic [XW-1:0] tag_d [N];
  logic [XW-1:0] tgt_q [N];
  logic [XW-1:0] tgt_d [N];
  dir_ctr_t      ctr_q [N];
  dir_ctr_t      ctr_d [N];
  logic [N-1:0]  ret_q, ret_d;
  logic          wr_any;

  assign wr_any    = wr_add | wr_del | wr_dir | wr_tgt;
  assign valid_vec = valid_q;

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    tgt_d   = tgt_q;
    ctr_d   = ctr_q;
    ret_d   = ret_q;
    if (wr_add) begin
      valid_d[add_idx] = 1'b1;
      tag_d[add_idx]   = up_pc;
      tgt_d[add_idx]   = up_target;
      ctr_d[add_idx]   = CTR_WEAK_TAKEN;
      ret_d[add_idx]   = add_ret;
    end else if (wr_del) begin
      valid_d[up_idx] = 1'b0;
    end else begin
      if (wr_dir) ctr_d[up_idx] = ctr_step(ctr_q[up_idx], up_taken);
      if (wr_tgt) tgt_d[up_idx] = up_target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_any) valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_any) begin
      tag_q <= tag_d;
      tgt_q <= tgt_d;
      ctr_q <= ctr_d;
      ret_q <= ret_d;
    end
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (valid_q[i] && tag_q[i] == lk_pc) begin
        lk_hit = 1'b1;
        lk_idx = IW'(i);
      end
    end
    lk_taken = lk_hit & ctr_q[lk_idx][1];
    lk_ret   = lk_hit & ret_q[lk_idx];
    lk_tgt   = lk_hit ? tgt_q[lk_idx] : '0;
  end

  // R3
  add_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_add |=> (valid_q[$past(add_idx)] && ctr_q[$past(add_idx)] == CTR_WEAK_TAKEN));
  // R5
  del_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_del && !wr_add) |=> !valid_q[$past(up_idx)]);
  // R6
  ctr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir && !wr_add && !wr_del && up_taken && ctr_q[up_idx] == 2'b11)
      |=> (ctr_q[$past(up_idx)] == 2'b11));
endmodule

// File: rtl/btb_rstack.sv
module btb_rstack #(
  parameter int DEPTH = 8,
  parameter int XW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [XW-1:0] push_val,
  output logic          nonempty,
  output logic [XW-1:0] top
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [XW-1:0] stk_q [DEPTH];
  logic [PW-1:0] ptr_q, ptr_d, ptr_inc, ptr_dec;
  logic [CW-1:0] cnt_q, cnt_d;

  assign ptr_inc  = (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  assign ptr_dec  = (ptr_q == '0) ? PW'(DEPTH - 1) : ptr_q - 1'b1;
  assign nonempty = (cnt_q != '0);
  assign top      = stk_q[ptr_dec];

  always_comb begin
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (push) begin
      ptr_d = ptr_inc;
      if (cnt_q != CW'(DEPTH)) cnt_d = cnt_q + 1'b1;
    end else if (pop && nonempty) begin
      ptr_d = ptr_dec;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (push || pop) begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) stk_q[ptr_q] <= push_val;
  end

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R10
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && cnt_q == CW'(DEPTH)) |=> (cnt_q == CW'(DEPTH)));
  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt_q == '0) |=> (cnt_q == '0 && $stable(ptr_q)));
endmodule

// File: rtl/btb_ras.sv
module btb_ras #(
  parameter int ENTRIES   = 32,
  parameter int RAS_DEPTH = 8,
  parameter int XLEN      = 32,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XLEN-1:0]  lk_pc,
  output logic             lk_hit,
  output logic             lk_taken,
  output logic [IDX_W-1:0] lk_idx,
  output logic [XLEN-1:0]  lk_target,
  input  logic             up_inst_valid,
  input  logic             up_ready_go,
  input  logic             up_next_ready,
  input  logic             up_fetch_excp,
  input  logic             up_add,
  input  logic             up_delete,
  input  logic             up_dir_err,
  input  logic             up_tgt_err,
  input  logic             up_confirm,
  input  logic             up_push,
  input  logic             up_pop,
  input  logic             up_taken,
  input  logic [IDX_W-1:0] up_idx,
  input  logic [XLEN-1:0]  up_pc,
  input  logic [XLEN-1:0]  up_target
);
  logic [1:0]         rst_sync;
  logic               rst_int_n;
  logic               accept;
  logic [ENTRIES-1:0] st_valid;
  logic [IDX_W-1:0]   alloc_idx;
  logic               st_ret, ras_nonempty;
  logic [XLEN-1:0]    st_tgt, ras_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign accept = up_inst_valid & up_ready_go & up_next_ready & ~up_fetch_excp;

  btb_alloc #(.N(ENTRIES), .IW(IDX_W)) u_alloc (
    .clk(clk), .rst_n(rst_int_n), .valid_vec(st_valid),
    .alloc_fire(accept & up_add), .alloc_idx(alloc_idx)
  );

  btb_store #(.N(ENTRIES), .IW(IDX_W), .XW(XLEN)) u_store (
    .clk(clk), .rst_n(rst_int_n), .lk_pc(lk_pc),
    .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_ret(st_ret),
    .lk_idx(lk_idx), .lk_tgt(st_tgt), .valid_vec(st_valid),
    .wr_add(accept & up_add), .add_idx(alloc_idx), .add_ret(up_pop),
    .wr_del(accept & up_delete), .wr_dir(accept & (up_dir_err | up_confirm)),
    .wr_tgt(accept & up_tgt_err), .up_idx(up_idx), .up_taken(up_taken),
    .up_pc(up_pc), .up_target(up_target)
  );

  btb_rstack #(.DEPTH(RAS_DEPTH), .XW(XLEN)) u_rstack (
    .clk(clk), .rst_n(rst_int_n), .push(accept & up_push),
    .pop(accept & up_pop), .push_val(up_pc + XLEN'(4)),
    .nonempty(ras_nonempty), .top(ras_top)
  );

  assign lk_target = (st_ret && ras_nonempty) ? ras_top : st_tgt;

  // R2
  no_accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !accept |=> $stable(st_valid));
  // R1
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !lk_hit |-> (!lk_taken && lk_target == '0 && lk_idx == '0));
endmodule

// File: tb/btb_ras_test.sv
module btb_ras_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_pc;
  logic        lk_hit, lk_taken;
  logic [4:0]  lk_idx;
  logic [31:0] lk_target;
  logic        up_inst_valid, up_ready_go, up_next_ready, up_fetch_excp;
  logic        up_add, up_delete, up_dir_err, up_tgt_err, up_confirm;
  logic        up_push, up_pop, up_taken;
  logic [4:0]  up_idx;
  logic [31:0] up_pc, up_target;

  int checks = 0;
  int fails  = 0;

  // reference model
  logic        mvalid [32];
  logic [31:0] mtag   [32];
  logic [31:0] mtgt   [32];
  logic [1:0]  mctr   [32];
  logic        mret   [32];
  int          vptr;
  logic [31:0] mstk   [8];
  int          mptr, mcnt;

  always #(CLK_P/2) clk = ~clk;

  btb_ras uut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
    .lk_taken(lk_taken), .lk_idx(lk_idx), .lk_target(lk_target),
    .up_inst_valid(up_inst_valid), .up_ready_go(up_ready_go),
    .up_next_ready(up_next_ready), .up_fetch_excp(up_fetch_excp),
    .up_add(up_add), .up_delete(up_delete), .up_dir_err(up_dir_err),
    .up_tgt_err(up_tgt_err), .up_confirm(up_confirm), .up_push(up_push),
    .up_pop(up_pop), .up_taken(up_taken), .up_idx(up_idx),
    .up_pc(up_pc), .up_target(up_target)
  );

  function automatic int find(input logic [31:0] pc);
    for (int i = 0; i < 32; i++)
      if (mvalid[i] && mtag[i] == pc) return i;
    return -1;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 32; i++) mvalid[i] = 1'b0;
    vptr = 0; mptr = 0; mcnt = 0;
  endtask

  task automatic model_update();
    int a;
    if (!(up_inst_valid && up_ready_go && up_next_ready && !up_fetch_excp)) return;
    if (up_add) begin
      a = -1;
      for (int i = 31; i >= 0; i--) if (!mvalid[i]) a = i;
      if (a < 0) begin a = vptr; vptr = (vptr + 1) % 32; end
      mvalid[a] = 1'b1; mtag[a] = up_pc; mtgt[a] = up_target;
      mctr[a] = 2'd2; mret[a] = up_pop;
    end else if (up_delete) begin
      mvalid[up_idx] = 1'b0;
    end else begin
      if (up_dir_err || up_confirm) begin
        if (up_taken && mctr[up_idx] != 2'd3) mctr[up_idx] = mctr[up_idx] + 2'd1;
        if (!up_taken && mctr[up_idx] != 2'd0) mctr[up_idx] = mctr[up_idx] - 2'd1;
      end
      if (up_tgt_err) mtgt[up_idx] = up_target;
    end
    if (up_push) begin
      mstk[mptr] = up_pc + 32'd4; mptr = (mptr + 1) % 8;
      if (mcnt < 8) mcnt++;
    end else if (up_pop && mcnt > 0) begin
      mptr = (mptr + 7) % 8; mcnt--;
    end
  endtask

  task automatic check_lk(input string rq);
    int m;
    logic eh, et;
    logic [4:0] ei;
    logic [31:0] eg;
    m  = find(lk_pc);
    eh = (m >= 0);
    ei = eh ? 5'(m) : 5'd0;
    et = eh && mctr[ei][1];
    eg = !eh ? 32'd0 : (mret[ei] && mcnt > 0) ? mstk[(mptr + 7) % 8] : mtgt[ei];
    checks++;
    if (lk_hit !== eh || lk_taken !== et || lk_idx !== ei || lk_target !== eg) begin
      fails++;
      $display("FAIL %s pc=%h: got hit=%b tk=%b idx=%0d tgt=%h, want hit=%b tk=%b idx=%0d tgt=%h",
               rq, lk_pc, lk_hit, lk_taken, lk_idx, lk_target, eh, et, ei, eg);
    end
  endtask

  task automatic idle();
    up_inst_valid = 1'b1; up_ready_go = 1'b1; up_next_ready = 1'b1; up_fetch_excp = 1'b0;
    up_add = 0; up_delete = 0; up_dir_err = 0; up_tgt_err = 0; up_confirm = 0;
    up_push = 0; up_pop = 0; up_taken = 0; up_idx = 0; up_pc = 0; up_target = 0;
  endtask

  task automatic step(input string rq);
    #(CLK_P/4);
    check_lk(rq);
    @(posedge clk);
    model_update();
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    model_clear();
    lk_pc = 32'h100;
    repeat (2) @(negedge clk);
    #(CLK_P/4) check_lk("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic add(input logic [31:0] pc, input logic [31:0] tg, input logic pop);
    up_add = 1; up_pc = pc; up_target = tg; up_pop = pop; up_taken = 1;
  endtask

  task automatic look(input logic [31:0] pc, input string rq);
    lk_pc = pc; step(rq);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int unsigned r;
    int m;
    rst_n = 1'b0;
    r = $urandom(32'd20240611);
    do_reset();
    look(32'h100, "R1");

    // R11 and R3: same-cycle lookup sees the old state, then the new slot
    lk_pc = 32'h1000; add(32'h1000, 32'h2000, 0); step("R11");
    look(32'h1000, "R3");

    // R2: each qualifier blocks the update
    lk_pc = 32'h1100; add(32'h1100, 32'h2100, 0); up_fetch_excp = 1; step("R2");
    look(32'h1100, "R2");
    add(32'h1100, 32'h2100, 0); up_next_ready = 0; step("R2");
    add(32'h1100, 32'h2100, 0); up_ready_go = 0; step("R2");
    add(32'h1100, 32'h2100, 0); up_inst_valid = 0; step("R2");
    look(32'h1100, "R2");

    // R6: walk the counter down and up, saturating both ends
    for (int k = 0; k < 3; k++) begin
      lk_pc = 32'h1000; up_dir_err = 1; up_taken = 0; up_idx = 0; step("R6");
    end
    for (int k = 0; k < 4; k++) begin
      lk_pc = 32'h1000; up_confirm = 1; up_taken = 1; up_idx = 0; step("R6");
    end
    look(32'h1000, "R6");

    // R7
    up_tgt_err = 1; up_idx = 0; up_target = 32'h2a00; lk_pc = 32'h1000; step("R11");
    look(32'h1000, "R7");

    // R5 then R3: freed slot reused first
    up_delete = 1; up_idx = 0; lk_pc = 32'h1000; step("R5");
    look(32'h1000, "R5");
    add(32'h1200, 32'h2200, 0); step("R3");
    look(32'h1200, "R3");

    // R12: add wins over delete, push wins over pop
    add(32'h1300, 32'h2300, 0); up_delete = 1; up_idx = 0; step("R12");
    look(32'h1300, "R12");
    look(32'h1200, "R12");

    // R8, R9, R10: return slot and stack
    do_reset();
    add(32'h3000, 32'h5554, 1); step("R9");
    look(32'h3000, "R9");
    up_push = 1; up_pc = 32'h700; lk_pc = 32'h3000; step("R11");
    look(32'h3000, "R8");
    up_push = 1; up_pop = 1; up_pc = 32'h7f0; step("R12");
    look(32'h3000, "R12");
    up_pop = 1; step("R9");
    up_pop = 1; step("R9");
    up_pop = 1; step("R9");
    look(32'h3000, "R9");
    for (int k = 1; k <= 9; k++) begin
      up_push = 1; up_pc = 32'(k * 32'h100); lk_pc = 32'h3000; step("R10");
    end
    for (int k = 0; k < 9; k++) begin
      lk_pc = 32'h3000; up_pop = 1; step("R10");
    end
    look(32'h3000, "R10");

    // R4: fill, then victim pointer order
    do_reset();
    for (int k = 0; k < 32; k++) begin
      add(32'h4000 + 32'(4 * k), 32'h6000 + 32'(k), 0); lk_pc = 32'h4000; step("R3");
    end
    add(32'h5000, 32'h7000, 0); step("R4");
    look(32'h5000, "R4");
    look(32'h4000, "R4");
    add(32'h5004, 32'h7004, 0); step("R4");
    look(32'h5004, "R4");
    up_delete = 1; up_idx = 5; step("R5");
    add(32'h5008, 32'h7008, 0); step("R3");
    look(32'h5008, "R3");
    add(32'h500c, 32'h700c, 0); step("R4");
    look(32'h500c, "R4");

    // random mix against the model
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      up_pc = 32'h8000 + 32'(4 * ($urandom % 48));
      lk_pc = ($urandom % 3 == 0) ? up_pc : 32'h8000 + 32'(4 * ($urandom % 48));
      up_inst_valid = ($urandom % 10) != 0;
      up_ready_go   = ($urandom % 10) != 0;
      up_next_ready = ($urandom % 10) != 0;
      up_fetch_excp = ($urandom % 10) == 0;
      up_taken  = $urandom % 2;
      up_target = 32'h9000 + 32'(4 * ($urandom % 256));
      r = $urandom % 8;
      up_push = (r == 0);
      up_pop  = (r == 1);
      m = find(up_pc);
      if (m < 0) up_add = $urandom % 2;
      else begin
        up_idx = 5'(m);
        r = $urandom % 5;
        up_delete  = (r == 0);
        up_dir_err = (r == 1);
        up_confirm = (r == 2);
        up_tgt_err = (r == 3);
      end
      step("R6");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule